// File: doc/BRIEF.md
# Low-Priority Interrupt Gating Controller

This block stands between an interrupt aggregator and a CPU core. It decides in which cycle a pending low-priority request may be taken. The aggregator presents a request level together with a vector number, a supervisor marker and the stack tag that the vector's link belongs to. The block compares that tag, and the core's current stack selector, against the stack that is configured for low-priority handlers. It grants the request only when the global enable flag permits it and the two stack selectors match.

A grant is a single-cycle take pulse, and the aggregator receives an acknowledge in the same cycle. Taking an interrupt clears the enable flag, so handlers do not nest by default. Software can set the flag with an enable-instruction strobe to allow nesting, and can clear it with a disable strobe. A supervisor-class request is taken even when the flag is clear. If the vector's link belongs to another stack, the block raises a non-maskable fault pulse instead of taking the request, and acknowledges it so that the fault is not raised again. A separate atomic-section counter is loaded by a strobe and counts down once per retired instruction packet. While the counter is non-zero, the block tells the real-time arbiter that preemption is blocked.

Top module: `lpi_gate_ctrl`

## Requirements
- R1: While `ie_flag` is 0, a request without `irq_super` produces no `take`, and the request stays pending until the flag allows it.
- R2: The cycle after a `take`, `ie_flag` reads 0.
- R3: `ins_enint` alone sets `ie_flag` on the next cycle and `ins_disint` clears it. If both strobes arrive in the same cycle, the disable wins.
- R4: A request with `irq_super` = 1 is taken whatever the value of `ie_flag`.
- R5: No `take` or `nmi_fault` occurs while `cur_stack` differs from `cfg_stack`. An eligible request is taken, combinationally, in the first cycle in which the two are equal.
- R6: An eligible request whose `irq_link` differs from `cfg_stack` raises `nmi_fault` and `ack` in that cycle, with `take` held at 0.
- R7: `take` implies `ack` in the same cycle. An `ack` blocks any new grant in the following cycle, so `take` never stays high for two cycles in a row.
- R8: When `ins_enint` and a `take` fall in the same cycle, `ie_flag` is 0 afterwards.
- R9: `ins_atomic` loads `atomic_len` into the atomic counter. Each `pkt_retire` decrements a non-zero count. When a load and a retire fall in the same cycle, the load wins. `rt_block` is 1 exactly while the count is non-zero.
- R10: After reset, `ie_flag` = 0, `rt_block` = 0, and no `nmi_fault` is present.
- R11: During a `take`, `take_vec` equals `irq_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Pending low-priority request level from the aggregator |
| irq_super | input | 1 | Request is supervisor class and ignores the enable flag |
| irq_vec | input | VEC_W | Vector number of the pending request |
| irq_link | input | STK_W | Stack tag that the vector's link belongs to |
| cfg_stack | input | STK_W | Stack configured for low-priority handlers |
| cur_stack | input | STK_W | Stack currently selected by the core |
| ins_enint | input | 1 | Enable-instruction strobe |
| ins_disint | input | 1 | Disable-instruction strobe |
| ins_atomic | input | 1 | Atomic-section strobe |
| atomic_len | input | CNT_W | Packet count loaded by the atomic strobe |
| pkt_retire | input | 1 | One instruction packet retired |
| take | output | 1 | Single-cycle grant of the request to the core |
| take_vec | output | VEC_W | Vector number that goes with the grant |
| ack | output | 1 | Acknowledge to the aggregator, for a grant or a fault |
| nmi_fault | output | 1 | Non-maskable fault pulse for a link on the wrong stack |
| ie_flag | output | 1 | Current global enable flag |
| rt_block | output | 1 | Real-time preemption blocked by an atomic section |

## Verification
Three pairs of events can land on the same clock edge: an enable strobe and a take, an enable strobe and a disable strobe, and an atomic load and a packet retire. Directed steps drive each pair together on purpose. A random phase produces many more such coincidences. The bench's behavioural model resolves each coincidence by the priority stated in the requirements: take before enable, disable before enable, load before decrement. On every cycle it compares the resulting flag, counter and pulses with the design's outputs.

// File: rtl/lpi_pkg.sv
// Shared definitions for the low-priority interrupt gate.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package lpi_pkg;
    // Update selected for the global enable flag in one cycle.
    typedef enum logic [1:0] {
        FLAG_KEEP = 2'd0,
        FLAG_SET  = 2'd1,
        FLAG_CLR  = 2'd2
    } flag_op_e;
endpackage

// File: rtl/lpi_enable_flag.sv
// Global enable flag for low-priority interrupts.
// What it does: holds the flag. A take clears it; otherwise a disable
// strobe clears it, and otherwise an enable strobe sets it.
// Assumes: the take input is the same-cycle grant from the decision logic.
module lpi_enable_flag
    import lpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_op_e op;
    logic     flag_q;

    // Pick the flag update: take, then disable, then enable.
    always_comb begin
        if (take_i || clr_i) begin
            op = FLAG_CLR;
        end else if (set_i) begin
            op = FLAG_SET;
        end else begin
            op = FLAG_KEEP;
        end
    end

    // Flag register; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            case (op)
                FLAG_SET: flag_q <= 1'b1;
                FLAG_CLR: flag_q <= 1'b0;
                default:  flag_q <= flag_q;
            endcase
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/lpi_take_decide.sv
// Combinational grant and fault decision.
// What it does: a request is eligible when no hold-off is active, the
// current stack equals the configured stack, and either the enable flag
// is set or the request is supervisor class. An eligible request whose
// link belongs to the configured stack is taken; any other eligible
// request raises a fault.
// Assumes: the request level stays up until it is acknowledged.
module lpi_take_decide #(
    parameter int STK_W = 2
) (
    input  logic             req_i,
    input  logic             super_i,
    input  logic             holdoff_i,
    input  logic             flag_i,
    input  logic [STK_W-1:0] cur_i,
    input  logic [STK_W-1:0] cfg_i,
    input  logic [STK_W-1:0] link_i,
    output logic             take_o,
    output logic             fault_o
);
    logic stack_ok;
    logic link_ok;
    logic allowed;
    logic eligible;

    // Split an eligible request into a grant or a fault.
    always_comb begin
        stack_ok = (cur_i == cfg_i);
        link_ok  = (link_i == cfg_i);
        allowed  = flag_i || super_i;
        eligible = req_i && !holdoff_i && stack_ok && allowed;
        take_o   = eligible && link_ok;
        fault_o  = eligible && !link_ok;
    end
endmodule

// File: rtl/lpi_atomic_ctr.sv
// Atomic-section packet counter.
// What it does: a strobe loads the count. Each retired packet decrements
// a non-zero count, and a load in the same cycle takes priority. The
// busy output stays high while the count is non-zero.
// Assumes: a length of zero ends any running section at once.
module lpi_atomic_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             pkt_i,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load, decrement or hold the packet count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (pkt_i && (cnt_q != ZERO)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign busy_o = (cnt_q != ZERO);
endmodule

// File: rtl/lpi_gate_ctrl.sv
// Top level of the low-priority interrupt gate.
// What it does: joins the enable flag, the take/fault decision and the
// atomic counter. After any acknowledge it blocks new grants for one
// cycle, which gives the aggregator time to drop the request.
// Assumes: every input is synchronous to clk.
module lpi_gate_ctrl #(
    parameter int VEC_W = 8,
    parameter int STK_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic             irq_super,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [STK_W-1:0] irq_link,
    input  logic [STK_W-1:0] cfg_stack,
    input  logic [STK_W-1:0] cur_stack,
    input  logic             ins_enint,
    input  logic             ins_disint,
    input  logic             ins_atomic,
    input  logic [CNT_W-1:0] atomic_len,
    input  logic             pkt_retire,
    output logic             take,
    output logic [VEC_W-1:0] take_vec,
    output logic             ack,
    output logic             nmi_fault,
    output logic             ie_flag,
    output logic             rt_block
);
    localparam logic [VEC_W-1:0] VEC_NONE = '0;

    logic take_w;
    logic fault_w;
    logic holdoff_q;

    lpi_take_decide #(.STK_W(STK_W)) u_decide (
        .req_i     (irq_req),
        .super_i   (irq_super),
        .holdoff_i (holdoff_q),
        .flag_i    (ie_flag),
        .cur_i     (cur_stack),
        .cfg_i     (cfg_stack),
        .link_i    (irq_link),
        .take_o    (take_w),
        .fault_o   (fault_w)
    );

    lpi_enable_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_w),
        .set_i  (ins_enint),
        .clr_i  (ins_disint),
        .flag_o (ie_flag)
    );

    lpi_atomic_ctr #(.CNT_W(CNT_W)) u_atomic (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ins_atomic),
        .len_i  (atomic_len),
        .pkt_i  (pkt_retire),
        .busy_o (rt_block)
    );

    // Block grants for one cycle after any acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holdoff_q <= 1'b0;
        end else begin
            holdoff_q <= take_w || fault_w;
        end
    end

    // Drive the outputs towards the core and the aggregator.
    always_comb begin
        take      = take_w;
        nmi_fault = fault_w;
        ack       = take_w || fault_w;
        take_vec  = take_w ? irq_vec : VEC_NONE;
    end
endmodule

// File: rtl/lpi_gate_checker.sv
// Assertion checker for lpi_gate_ctrl, bound into every instance.
// What it does: watches the ports for the timing rules of the requirements.
// Assumes: sampled on the rising clock edge, disabled during reset.
module lpi_gate_checker #(
    parameter int VEC_W = 8,
    parameter int STK_W = 2,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_super,
    input logic [VEC_W-1:0] irq_vec,
    input logic [STK_W-1:0] irq_link,
    input logic [STK_W-1:0] cfg_stack,
    input logic [STK_W-1:0] cur_stack,
    input logic             ins_enint,
    input logic             ins_disint,
    input logic             ins_atomic,
    input logic [CNT_W-1:0] atomic_len,
    input logic             take,
    input logic [VEC_W-1:0] take_vec,
    input logic             ack,
    input logic             nmi_fault,
    input logic             ie_flag,
    input logic             rt_block
);
    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !irq_super) |-> ie_flag);
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ie_flag);
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_enint && !ins_disint && !take) |=> ie_flag);
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_disint |=> !ie_flag);
    p_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take || nmi_fault) |-> (cur_stack == cfg_stack));
    p_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_fault |-> (!take && ack && (irq_link != cfg_stack)));
    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ack);
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !take);
    p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ins_enint) |=> !ie_flag);
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_atomic |=> (rt_block == ($past(atomic_len) != '0)));
    p_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_vec == irq_vec));
endmodule

bind lpi_gate_ctrl lpi_gate_checker #(
    .VEC_W(VEC_W), .STK_W(STK_W), .CNT_W(CNT_W)
) i_lpi_gate_checker (
    .clk(clk), .rst_n(rst_n), .irq_super(irq_super), .irq_vec(irq_vec),
    .irq_link(irq_link), .cfg_stack(cfg_stack), .cur_stack(cur_stack),
    .ins_enint(ins_enint), .ins_disint(ins_disint), .ins_atomic(ins_atomic),
    .atomic_len(atomic_len), .take(take), .take_vec(take_vec), .ack(ack),
    .nmi_fault(nmi_fault), .ie_flag(ie_flag), .rt_block(rt_block)
);

// File: tb/test_lpi_gate_ctrl.sv
// Self-checking bench for lpi_gate_ctrl. A behavioural model runs beside
// the design and is compared with it on every clock.
module test_lpi_gate_ctrl;
    localparam int VEC_W = 8;
    localparam int STK_W = 2;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             irq_req = 1'b0, irq_super = 1'b0;
    logic [VEC_W-1:0] irq_vec = '0;
    logic [STK_W-1:0] irq_link = '0, cfg_stack = '0, cur_stack = '0;
    logic             ins_enint = 1'b0, ins_disint = 1'b0, ins_atomic = 1'b0;
    logic [CNT_W-1:0] atomic_len = '0;
    logic             pkt_retire = 1'b0;
    logic             take, ack, nmi_fault, ie_flag, rt_block;
    logic [VEC_W-1:0] take_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state
    bit m_ie = 0, m_hold = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    lpi_gate_ctrl #(.VEC_W(VEC_W), .STK_W(STK_W), .CNT_W(CNT_W)) i_lpi_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_super(irq_super),
        .irq_vec(irq_vec), .irq_link(irq_link), .cfg_stack(cfg_stack),
        .cur_stack(cur_stack), .ins_enint(ins_enint), .ins_disint(ins_disint),
        .ins_atomic(ins_atomic), .atomic_len(atomic_len), .pkt_retire(pkt_retire),
        .take(take), .take_vec(take_vec), .ack(ack), .nmi_fault(nmi_fault),
        .ie_flag(ie_flag), .rt_block(rt_block)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Inputs were just driven after a falling edge: compare, advance the model.
    task automatic cycle();
        bit elig, e_take, e_fault;
        #1;
        elig    = irq_req && !m_hold && (cur_stack == cfg_stack) && (m_ie || irq_super);
        e_take  = elig && (irq_link == cfg_stack);
        e_fault = elig && (irq_link != cfg_stack);
        chk("R1/R4/R5 take", int'(take), int'(e_take));
        chk("R6 nmi_fault", int'(nmi_fault), int'(e_fault));
        chk("R7 ack", int'(ack), int'(e_take || e_fault));
        chk("R2/R3/R8 ie_flag", int'(ie_flag), int'(m_ie));
        chk("R9 rt_block", int'(rt_block), int'(m_cnt != 0));
        if (e_take) chk("R11 take_vec", int'(take_vec), int'(irq_vec));
        m_hold = e_take || e_fault;
        if (e_take || ins_disint) m_ie = 0;
        else if (ins_enint) m_ie = 1;
        if (ins_atomic) m_cnt = int'(atomic_len);
        else if (pkt_retire && m_cnt > 0) m_cnt--;
        @(negedge clk);
        ins_enint = 0; ins_disint = 0; ins_atomic = 0; pkt_retire = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset ie_flag", int'(ie_flag), 0);
        chk("R10 reset rt_block", int'(rt_block), 0);
        chk("R10 reset nmi_fault", int'(nmi_fault), 0);
        rst_n = 1;
        @(negedge clk);
        cfg_stack = 2'd1; cur_stack = 2'd1; irq_link = 2'd1; irq_vec = 8'h21;

        // R1: request with flag clear stays pending
        irq_req = 1;
        repeat (3) cycle();
        // R3: enable strobe, then take on the following cycle (R2)
        ins_enint = 1; cycle();
        cycle();
        irq_req = 0; cycle(); cycle();

        // R5: stack mismatch holds the request, take on first match
        ins_enint = 1; cycle();
        cur_stack = 2'd2; irq_req = 1; irq_vec = 8'h5a;
        repeat (3) cycle();
        cur_stack = 2'd1; cycle();
        irq_req = 0; cycle();

        // R4: supervisor ignores a clear flag
        irq_req = 1; irq_super = 1; irq_vec = 8'h77; cycle();
        irq_req = 0; irq_super = 0; cycle();

        // R6: link on another stack raises a fault
        ins_enint = 1; cycle();
        irq_req = 1; irq_link = 2'd3; cycle();
        irq_req = 0; irq_link = 2'd1; cycle();

        // R8: enable strobe in the same cycle as a take
        irq_req = 1; ins_enint = 1; cycle();
        irq_req = 0; cycle();
        // R3: enable and disable together, disable wins
        ins_enint = 1; ins_disint = 1; cycle();
        cycle();

        // R9: atomic load, decrement, load beats retire
        ins_atomic = 1; atomic_len = 4'd2; cycle();
        pkt_retire = 1; cycle();
        pkt_retire = 1; cycle();
        pkt_retire = 1; cycle();
        ins_atomic = 1; atomic_len = 4'd3; cycle();
        ins_atomic = 1; atomic_len = 4'd5; pkt_retire = 1; cycle();
        cycle();

        // Random phase, every rule together
        for (int i = 0; i < 2000; i++) begin
            irq_req    = ($urandom % 3) != 0;
            irq_super  = ($urandom % 5) == 0;
            irq_vec    = VEC_W'($urandom);
            irq_link   = ($urandom % 6 == 0) ? STK_W'($urandom) : cfg_stack;
            cur_stack  = ($urandom % 3 == 0) ? STK_W'($urandom) : cfg_stack;
            ins_enint  = ($urandom % 4) == 0;
            ins_disint = ($urandom % 7) == 0;
            ins_atomic = ($urandom % 9) == 0;
            atomic_len = CNT_W'($urandom);
            pkt_retire = ($urandom % 2) == 0;
            cycle();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule